// File: doc/BRIEF.md
# Ping-Pong Block Prefetch Controller

This controller manages a pair of local block buffers that sit between an external memory and a compute engine. A dispatcher hands it block addresses. For each one it issues a single read request to a DMA-style port, aimed at whichever buffer is free. The fills alternate between the two buffers, so that the next block can arrive while the engine is still working on the current one.

When a fill lands, the controller raises a per-buffer completion flag and holds a level interrupt toward the dispatcher. The dispatcher acknowledges a flag by writing one to it. Only once that flag is clear may the engine claim the buffer. When the engine reports that it has finished a block, that buffer returns to the free pool and the engine moves to the other buffer. Each buffer steps through four states: empty, filling, full and busy. At most one fill is in flight at a time. A dispatcher request that finds no free target is held off with a ready signal and is never lost.

Top module: `ppf_ctrl`

## Requirements
- R1: After reset both buffers are empty. In that state `blk_ready` is 1, while `dma_req`, `sem`, `irq` and `eng_avail` are all 0.
- R2: A block accepted on a cycle where `blk_valid` and `blk_ready` are both 1 raises `dma_req` on the next cycle. The request carries `dma_addr` equal to the accepted address, `dma_buf` naming the target buffer, and `dma_len` equal to `BLK_BYTES`. `dma_req` and `dma_addr` hold until a cycle with `dma_ack` high.
- R3: Fills alternate between buffers. The first fill after reset targets buffer 0 (`dma_buf`=0). Every completed fill flips the target to the other buffer.
- R4: A `dma_done` pulse that arrives after the request was acknowledged sets bit `dma_buf` of `sem` on the next cycle. `irq` is high while any `sem` bit is 1. A `sem` bit stays set until the cycle after `sem_w1c` carries a 1 in that position, and zero bits in `sem_w1c` have no effect. A `dma_done` pulse with no fill in flight changes nothing.
- R5: `eng_avail` is 1 only when the buffer named by `eng_buf` is full and its `sem` bit is 0. The first buffer to be consumed after reset is buffer 0.
- R6: `eng_start` while `eng_avail` is 1 makes that buffer busy, and `eng_avail` drops on the next cycle. `eng_start` while `eng_avail` is 0 has no effect.
- R7: `eng_done` while a buffer is busy returns that buffer to empty and flips `eng_buf` to the other buffer on the next cycle. `eng_done` with no buffer busy is ignored.
- R8: While one buffer is busy with the engine, a block may be accepted and fetched into the other buffer.
- R9: `blk_ready` is 0 while the target buffer is filling, full or busy. A request held with `blk_valid` high during the stall is accepted, address unchanged, once the target buffer frees.
- R10: A fill completion and an engine completion in the same cycle both take effect: one buffer becomes full with its flag set, and the other becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Dispatcher offers a block address |
| blk_addr | input | ADDR_W | External address of the offered block |
| blk_ready | output | 1 | A free buffer can take the offered block |
| dma_req | output | 1 | Read request to the transfer port |
| dma_addr | output | ADDR_W | Source address of the request |
| dma_buf | output | 1 | Target buffer index of the request |
| dma_len | output | LEN_W | Transfer length in bytes |
| dma_ack | input | 1 | Transfer port accepted the request |
| dma_done | input | 1 | Pulse: the accepted transfer finished |
| sem | output | 2 | Per-buffer completion flags |
| sem_w1c | input | 2 | Write-one-to-clear for the flags |
| irq | output | 1 | Level interrupt while any flag is set |
| eng_avail | output | 1 | Buffer `eng_buf` may be claimed by the engine |
| eng_buf | output | 1 | Buffer the engine consumes next or now |
| eng_start | input | 1 | Engine claims buffer `eng_buf` |
| eng_done | input | 1 | Engine finished its current buffer |

## Verification
Two things can land in the same clock edge: the end of a fill into one buffer and the engine's completion on the other. The bench provokes this with a busy engine on buffer 1 and a fetch into buffer 0 in flight. It pulses `dma_done` and `eng_done` together, then judges that afterwards only bit 0 of `sem` is set, that `blk_ready` returns for buffer 1, and that `eng_avail` rises on buffer 0 once its flag is written clear. A second overlap is also exercised: a held dispatcher request is taken on the edge right after the engine frees the buffer, while the engine claims the other buffer one edge later.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_FILLING = 2'd1,
        SLOT_FULL    = 2'd2,
        SLOT_BUSY    = 2'd3
    } slot_state_e;

    localparam int unsigned SLOT_COUNT = 2;

endpackage

// File: rtl/ppf_slot.sv
module ppf_slot
    import ppf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fill_go,
    input  logic        fill_end,
    input  logic        run_go,
    input  logic        run_end,
    input  logic        flag_clr,
    output slot_state_e state,
    output logic        flag
);

    typedef struct packed {
        slot_state_e st;
        logic        flag;
    } slot_reg_t;

    slot_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (flag_clr) begin
            r_d.flag = 1'b0;
        end
        case (r_q.st)
            SLOT_EMPTY: begin
                if (fill_go) r_d.st = SLOT_FILLING;
            end
            SLOT_FILLING: begin
                if (fill_end) begin
                    r_d.st   = SLOT_FULL;
                    r_d.flag = 1'b1;
                end
            end
            SLOT_FULL: begin
                if (run_go) r_d.st = SLOT_BUSY;
            end
            SLOT_BUSY: begin
                if (run_end) r_d.st = SLOT_EMPTY;
            end
            default: r_d.st = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: SLOT_EMPTY, flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign flag  = r_q.flag;

endmodule

// File: rtl/ppf_fill_ctrl.sv
module ppf_fill_ctrl
    import ppf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blk_valid,
    input  logic [ADDR_W-1:0]     blk_addr,
    output logic                  blk_ready,
    input  logic [SLOT_COUNT-1:0] slot_empty,
    output logic                  dma_req,
    output logic [ADDR_W-1:0]     dma_addr,
    output logic                  dma_buf,
    input  logic                  dma_ack,
    input  logic                  dma_done,
    output logic [SLOT_COUNT-1:0] fill_go,
    output logic [SLOT_COUNT-1:0] fill_end
);

    typedef struct packed {
        logic              ptr;
        logic              req;
        logic              wait_done;
        logic [ADDR_W-1:0] addr;
    } fill_reg_t;

    fill_reg_t f_d, f_q;
    logic      accept;
    logic      finish;

    always_comb begin
        f_d       = f_q;
        fill_go   = '0;
        fill_end  = '0;
        blk_ready = slot_empty[f_q.ptr];
        accept    = blk_valid & blk_ready;
        finish    = f_q.wait_done & dma_done;

        if (accept) begin
            f_d.req         = 1'b1;
            f_d.addr        = blk_addr;
            fill_go[f_q.ptr] = 1'b1;
        end
        if (f_q.req && dma_ack) begin
            f_d.req       = 1'b0;
            f_d.wait_done = 1'b1;
        end
        if (finish) begin
            f_d.wait_done     = 1'b0;
            f_d.ptr           = ~f_q.ptr;
            fill_end[f_q.ptr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dma_req  = f_q.req;
    assign dma_addr = f_q.addr;
    assign dma_buf  = f_q.ptr;

endmodule

// File: rtl/ppf_run_ctrl.sv
module ppf_run_ctrl
    import ppf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SLOT_COUNT-1:0] slot_full,
    input  logic [SLOT_COUNT-1:0] slot_busy,
    input  logic [SLOT_COUNT-1:0] flag,
    input  logic                  eng_start,
    input  logic                  eng_done,
    output logic                  eng_avail,
    output logic                  eng_buf,
    output logic [SLOT_COUNT-1:0] run_go,
    output logic [SLOT_COUNT-1:0] run_end
);

    typedef struct packed {
        logic ptr;
    } run_reg_t;

    run_reg_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        run_go    = '0;
        run_end   = '0;
        eng_avail = slot_full[c_q.ptr] & ~flag[c_q.ptr];
        if (eng_start && eng_avail) begin
            run_go[c_q.ptr] = 1'b1;
        end
        if (eng_done && slot_busy[c_q.ptr]) begin
            run_end[c_q.ptr] = 1'b1;
            c_d.ptr          = ~c_q.ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign eng_buf = c_q.ptr;

endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl
    import ppf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLK_BYTES = 4096,
    parameter int unsigned LEN_W     = $clog2(BLK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic              blk_ready,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_buf,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_ack,
    input  logic              dma_done,
    output logic [1:0]        sem,
    input  logic [1:0]        sem_w1c,
    output logic              irq,
    output logic              eng_avail,
    output logic              eng_buf,
    input  logic              eng_start,
    input  logic              eng_done
);

    localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(BLK_BYTES);

    logic [SLOT_COUNT-1:0] fill_go, fill_end, run_go, run_end;
    logic [SLOT_COUNT-1:0] slot_empty, slot_full, slot_busy, flag;
    slot_state_e           slot_st [SLOT_COUNT];

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        ppf_slot slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_go  (fill_go[g]),
            .fill_end (fill_end[g]),
            .run_go   (run_go[g]),
            .run_end  (run_end[g]),
            .flag_clr (sem_w1c[g]),
            .state    (slot_st[g]),
            .flag     (flag[g])
        );
        assign slot_empty[g] = (slot_st[g] == SLOT_EMPTY);
        assign slot_full[g]  = (slot_st[g] == SLOT_FULL);
        assign slot_busy[g]  = (slot_st[g] == SLOT_BUSY);
    end

    ppf_fill_ctrl #(.ADDR_W(ADDR_W)) fill_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_valid  (blk_valid),
        .blk_addr   (blk_addr),
        .blk_ready  (blk_ready),
        .slot_empty (slot_empty),
        .dma_req    (dma_req),
        .dma_addr   (dma_addr),
        .dma_buf    (dma_buf),
        .dma_ack    (dma_ack),
        .dma_done   (dma_done),
        .fill_go    (fill_go),
        .fill_end   (fill_end)
    );

    ppf_run_ctrl run_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_full (slot_full),
        .slot_busy (slot_busy),
        .flag      (flag),
        .eng_start (eng_start),
        .eng_done  (eng_done),
        .eng_avail (eng_avail),
        .eng_buf   (eng_buf),
        .run_go    (run_go),
        .run_end   (run_end)
    );

    assign dma_len = BLK_LEN;
    assign sem     = flag;
    assign irq     = |flag;

endmodule

// File: rtl/ppf_ctrl_chk.sv
module ppf_ctrl_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blk_ready,
    input logic              dma_req,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              dma_buf,
    input logic              dma_ack,
    input logic              dma_done,
    input logic [1:0]        sem,
    input logic [1:0]        sem_w1c,
    input logic              eng_avail,
    input logic              eng_buf,
    input logic              eng_start
);

    // R2: an unacknowledged request keeps its address
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req && $stable(dma_addr));

    // R4: a flag only rises after a completion aimed at that buffer
    p_sem_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sem[0]) |-> $past(dma_done) && ($past(dma_buf) == 1'b0));

    // R4: a set flag survives until written clear
    p_sem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sem[1] && !sem_w1c[1] |=> sem[1]);

    // R5: the engine never sees a buffer whose flag is pending
    p_avail_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_avail |-> (sem[eng_buf] == 1'b0));

    // R6: a claimed buffer is no longer offered
    p_start_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start && eng_avail |=> !eng_avail);

    // R9: no new block is taken while a fetch is still requested
    p_one_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !blk_ready);

endmodule

bind ppf_ctrl ppf_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_ready (blk_ready),
    .dma_req   (dma_req),
    .dma_addr  (dma_addr),
    .dma_buf   (dma_buf),
    .dma_ack   (dma_ack),
    .dma_done  (dma_done),
    .sem       (sem),
    .sem_w1c   (sem_w1c),
    .eng_avail (eng_avail),
    .eng_buf   (eng_buf),
    .eng_start (eng_start)
);

// File: tb/ppf_ctrl_tb.sv
module ppf_ctrl_tb_top;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned BLK_BYTES = 4096;
    localparam int unsigned LEN_W     = $clog2(BLK_BYTES) + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              blk_valid;
    logic [ADDR_W-1:0] blk_addr;
    logic              blk_ready;
    logic              dma_req;
    logic [ADDR_W-1:0] dma_addr;
    logic              dma_buf;
    logic [LEN_W-1:0]  dma_len;
    logic              dma_ack;
    logic              dma_done;
    logic [1:0]        sem;
    logic [1:0]        sem_w1c;
    logic              irq;
    logic              eng_avail;
    logic              eng_buf;
    logic              eng_start;
    logic              eng_done;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              buf_idx;
    } exp_req_t;

    exp_req_t exp_q[$];

    always #4 clk = ~clk;

    ppf_ctrl #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .blk_addr  (blk_addr),
        .blk_ready (blk_ready),
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .dma_buf   (dma_buf),
        .dma_len   (dma_len),
        .dma_ack   (dma_ack),
        .dma_done  (dma_done),
        .sem       (sem),
        .sem_w1c   (sem_w1c),
        .irq       (irq),
        .eng_avail (eng_avail),
        .eng_buf   (eng_buf),
        .eng_start (eng_start),
        .eng_done  (eng_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock edge passes; inputs change and checks happen 1 ns after the falling edge
    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    // driver: offers a block and records the fetch it must produce
    task automatic offer(input logic [ADDR_W-1:0] a, input logic b);
        blk_valid = 1'b1;
        blk_addr  = a;
        exp_q.push_back('{addr: a, buf_idx: b});
    endtask

    // monitor: every handshaken fetch is compared with the scoreboard
    always @(negedge clk) begin
        #3;
        if (rst_n && dma_req && dma_ack) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: actual fetch %0h with no expected entry, expected none", dma_addr);
            end else begin
                exp_req_t e;
                e = exp_q.pop_front();
                if (dma_addr !== e.addr || dma_buf !== e.buf_idx) begin
                    n_fail++;
                    $display("FAIL R3: actual addr %0h buf %0d expected addr %0h buf %0d",
                             dma_addr, dma_buf, e.addr, e.buf_idx);
                end
            end
        end
    end

    task automatic run_seq();
        rst_n = 1'b0; blk_valid = 1'b0; blk_addr = '0; dma_ack = 1'b0;
        dma_done = 1'b0; sem_w1c = '0; eng_start = 1'b0; eng_done = 1'b0;
        nxt(); nxt(); nxt();
        rst_n = 1'b1;
        nxt();
        // R1 reset state
        chk("R1 ready", blk_ready, 1);
        chk("R1 req", dma_req, 0);
        chk("R1 sem", sem, 0);
        chk("R1 irq", irq, 0);
        chk("R1 avail", eng_avail, 0);

        // R2 first fetch, held without ack
        offer(32'h0000_1000, 1'b0);
        nxt();
        blk_valid = 1'b0;
        chk("R2 req", dma_req, 1);
        chk("R2 addr", dma_addr, 32'h0000_1000);
        chk("R3 first buf", dma_buf, 0);
        chk("R2 len", dma_len, BLK_BYTES);
        chk("R9 busy fill", blk_ready, 0);
        nxt();
        chk("R2 hold req", dma_req, 1);
        chk("R2 hold addr", dma_addr, 32'h0000_1000);
        dma_ack = 1'b1;
        nxt();
        chk("R2 ack drop", dma_req, 0);
        dma_done = 1'b1;
        nxt();
        dma_done = 1'b0;
        chk("R4 sem set", sem, 2'b01);
        chk("R4 irq", irq, 1);
        chk("R5 flag pending", eng_avail, 0);
        chk("R3 other free", blk_ready, 1);

        // R3 second fetch goes to buffer 1
        offer(32'h0000_2000, 1'b1);
        nxt();
        blk_valid = 1'b0;
        chk("R3 second buf", dma_buf, 1);
        nxt();
        dma_done = 1'b1;
        nxt();
        dma_done = 1'b0;
        chk("R4 both set", sem, 2'b11);
        chk("R9 both full", blk_ready, 0);

        // R9 stall of a held request
        offer(32'h0000_3000, 1'b0);
        nxt();
        chk("R9 stalled req", dma_req, 0);
        chk("R9 stalled ready", blk_ready, 0);
        dma_done = 1'b1;
        nxt();
        dma_done = 1'b0;
        chk("R4 stray done", sem, 2'b11);

        sem_w1c = 2'b10;
        nxt();
        sem_w1c = 2'b00;
        chk("R4 clear one", sem, 2'b01);
        chk("R4 irq held", irq, 1);
        chk("R5 buf0 pending", eng_avail, 0);
        eng_start = 1'b1;
        nxt();
        eng_start = 1'b0;
        sem_w1c = 2'b01;
        nxt();
        sem_w1c = 2'b00;
        chk("R4 all clear", sem, 2'b00);
        chk("R4 irq low", irq, 0);
        chk("R6 ignored start", eng_avail, 1);
        chk("R5 order", eng_buf, 0);

        eng_start = 1'b1;
        nxt();
        eng_start = 1'b0;
        chk("R6 claim", eng_avail, 0);
        chk("R9 still stalled", blk_ready, 0);
        eng_done = 1'b1;
        nxt();
        eng_done = 1'b0;
        chk("R7 next buf", eng_buf, 1);
        chk("R7 next avail", eng_avail, 1);
        chk("R7 freed", blk_ready, 1);

        // held request taken now; engine claims buffer 1 one edge later
        nxt();
        blk_valid = 1'b0;
        eng_start = 1'b1;
        chk("R9 kept addr", dma_addr, 32'h0000_3000);
        chk("R9 kept req", dma_req, 1);
        nxt();
        eng_start = 1'b0;
        chk("R8 overlap fetch", dma_buf, 0);
        chk("R8 engine busy", eng_avail, 0);

        // R10 fill end and engine end in one cycle
        dma_done = 1'b1;
        eng_done = 1'b1;
        nxt();
        dma_done = 1'b0;
        eng_done = 1'b0;
        chk("R10 sem", sem, 2'b01);
        chk("R10 freed", blk_ready, 1);
        chk("R10 ptr", eng_buf, 0);
        chk("R10 pending", eng_avail, 0);
        sem_w1c = 2'b01;
        nxt();
        sem_w1c = 2'b00;
        chk("R10 avail", eng_avail, 1);

        eng_done = 1'b1;
        nxt();
        eng_done = 1'b0;
        chk("R7 stray done", eng_avail, 1);
        chk("R7 stray ptr", eng_buf, 0);

        nxt();
        chk("R2 all fetches seen", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run_seq();
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule